// File: doc/BRIEF.md
# Serial Port Interrupt Status Logic

This block produces the raw and masked interrupt status for a synchronous serial port controller. It watches the occupancy counts of the transmit and receive FIFOs and a set of single-cycle strobes from the rest of the controller: receive overrun, receive timeout, receive and transmit DMA completion, and end of transmit. From these inputs it keeps a seven-bit raw status word. Two of its bits follow the FIFO levels and clear themselves. The other five are sticky event flags that only software can clear.

Software reaches the block through a small register port with four word addresses. Address 0 is the raw status, and it is read-only. Address 1 is the interrupt mask, which can be read and written. Address 2 is the masked status, and it is read-only. Address 3 is the write-one-to-clear register, which always reads as zero. Reads are combinational from the address. A write takes effect at the clock edge at which `bus_wr` is high. The single interrupt line is the OR of all masked status bits. No data stream passes through this block, so every pin is a plain control or status signal and the block has no handshake.

Top module: `ssp_irq_status`

## Requirements
- R1: The raw status bit positions are fixed as follows. Bit 0 is receive overrun, bit 1 is receive timeout, bit 2 is the receive FIFO threshold, bit 3 is the transmit FIFO threshold, bit 4 is receive DMA done, bit 5 is transmit DMA done and bit 6 is end of transmit. Bits 31..7 of every read are zero.
- R2: After reset the raw status reads 0x8, and the mask and the masked status read 0.
- R3: A write to address 0 (raw status) changes no state.
- R4: Bit 3 is 1 when the transmit occupancy sampled at the previous clock edge was at most DEPTH/2, and 0 otherwise.
- R5: Bit 2 is 1 when the receive occupancy sampled at the previous clock edge was at least DEPTH/2, and 0 otherwise.
- R6: Bit 6 sets one edge after `eot_pulse`, but only if `tx_level` was 0 in that same cycle. A pulse while the transmit FIFO still holds data is ignored.
- R7: Bits 0, 1, 4, 5 and 6 are sticky. Each stays set until a write to address 3 with a 1 in the same bit position. Zeros in the clear data have no effect, and ones in bits 2 and 3 have no effect.
- R8: Bit 0 sets one edge after `rx_push` is high while `rx_level` equals DEPTH. A push into a FIFO that is not full does not set it.
- R9: When a set event and a clear hit the same sticky bit in the same cycle, the bit ends up set.
- R10: Address 1 holds the 7-bit mask and reads it back. Address 2 reads raw AND mask. `irq` is high exactly when any masked bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_level | input | CNT_W | Transmit FIFO occupancy, 0..DEPTH |
| rx_level | input | CNT_W | Receive FIFO occupancy, 0..DEPTH |
| rx_push | input | 1 | A received word is arriving at the receive FIFO |
| rx_timeout | input | 1 | Receive timeout strobe |
| dma_rx_done | input | 1 | Receive DMA completion strobe |
| dma_tx_done | input | 1 | Transmit DMA completion strobe |
| eot_pulse | input | 1 | Shifter has sent its last bit |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 7 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from the address |
| irq | output | 1 | Combined masked interrupt |

## Verification
The raw status and the masked status are compared with a bench model after every clock, so any wrong internal state shows up within one clock. A sticky flag that is lost or set in error shows as a mismatched raw bit on the very next read. A threshold register that lags its FIFO level or uses the wrong comparison shows at the boundary occupancies DEPTH/2 and DEPTH/2 ± 1. A mask register that is corrupted shows at once on `irq` and on the masked status, and mask writes are mixed at random into the raw-address writes.

// File: rtl/ssp_irq_pkg.sv
package ssp_irq_pkg;
  localparam int STAT_W = 7;
  localparam int BUS_W  = 32;

  localparam int B_OVR   = 0;
  localparam int B_TOUT  = 1;
  localparam int B_RXTHR = 2;
  localparam int B_TXTHR = 3;
  localparam int B_DRX   = 4;
  localparam int B_DTX   = 5;
  localparam int B_EOT   = 6;

  typedef enum logic [1:0] {
    A_RAW    = 2'd0,
    A_MASK   = 2'd1,
    A_MASKED = 2'd2,
    A_CLEAR  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/ssp_irq_level.sv
module ssp_irq_level #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_level,
  output logic             tx_thr,
  output logic             rx_thr
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_thr <= 1'b1;
      rx_thr <= 1'b0;
    end else begin
      tx_thr <= (tx_level <= HALF);
      rx_thr <= (rx_level >= HALF);
    end
  end

  assert_tx_thr_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level > HALF) |=> !tx_thr);
  assert_rx_thr_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level < HALF) |=> !rx_thr);
endmodule

// File: rtl/ssp_irq_sticky.sv
module ssp_irq_sticky #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)         flag_o[i] <= 1'b0;
      else if (set_i[i])  flag_o[i] <= 1'b1;
      else if (clr_i[i])  flag_o[i] <= 1'b0;
    end

    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_o[i]);
  end
endmodule

// File: rtl/ssp_irq_regs.sv
module ssp_irq_regs
  import ssp_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [STAT_W-1:0] bus_wdata,
  input  logic [STAT_W-1:0] raw,
  output logic [STAT_W-1:0] clr_req,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] masked;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata;
  end

  assign masked  = raw & mask_q;
  assign irq     = |masked;
  assign clr_req = (bus_wr && bus_addr == A_CLEAR) ? bus_wdata : '0;

  always_comb begin
    bus_rdata = '0;
    case (reg_addr_e'(bus_addr))
      A_RAW:    bus_rdata[STAT_W-1:0] = raw;
      A_MASK:   bus_rdata[STAT_W-1:0] = mask_q;
      A_MASKED: bus_rdata[STAT_W-1:0] = masked;
      default:  bus_rdata = '0;
    endcase
  end

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
  assert_raw_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_RAW) |=> $stable(mask_q));
endmodule

// File: rtl/ssp_irq_status.sv
module ssp_irq_status
  import ssp_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  tx_level,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic              rx_push,
  input  logic              rx_timeout,
  input  logic              dma_rx_done,
  input  logic              dma_tx_done,
  input  logic              eot_pulse,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [STAT_W-1:0] bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int NSTK = 5;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic              tx_thr, rx_thr;
  logic [NSTK-1:0]   stk_set, stk_clr, stk_q;
  logic [STAT_W-1:0] raw, clr_req;
  logic              ovr_evt, eot_evt;

  assign ovr_evt = rx_push && (rx_level == FULL);
  assign eot_evt = eot_pulse && (tx_level == '0);

  // sticky slot order: ovr, tout, drx, dtx, eot
  assign stk_set = {eot_evt, dma_tx_done, dma_rx_done, rx_timeout, ovr_evt};
  assign stk_clr = {clr_req[B_EOT], clr_req[B_DTX], clr_req[B_DRX],
                    clr_req[B_TOUT], clr_req[B_OVR]};

  ssp_irq_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) level_i (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .tx_thr(tx_thr), .rx_thr(rx_thr)
  );

  ssp_irq_sticky #(.N(NSTK)) sticky_i (
    .clk(clk), .rst_n(rst_n), .set_i(stk_set), .clr_i(stk_clr), .flag_o(stk_q)
  );

  always_comb begin
    raw          = '0;
    raw[B_OVR]   = stk_q[0];
    raw[B_TOUT]  = stk_q[1];
    raw[B_RXTHR] = rx_thr;
    raw[B_TXTHR] = tx_thr;
    raw[B_DRX]   = stk_q[2];
    raw[B_DTX]   = stk_q[3];
    raw[B_EOT]   = stk_q[4];
  end

  ssp_irq_regs regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .raw(raw), .clr_req(clr_req),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  assert_eot_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw[B_EOT] && !(eot_pulse && tx_level == '0)) |=> !raw[B_EOT]);
  assert_ovr_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw[B_OVR] && !(rx_push && rx_level == FULL)) |=> !raw[B_OVR]);
endmodule

// File: tb/ssp_irq_status_tb.sv
module ssp_irq_status_tb_top;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic [CNT_W-1:0] tx_level = 0, rx_level = 0;
  logic rx_push = 0, rx_timeout = 0, dma_rx_done = 0, dma_tx_done = 0, eot_pulse = 0;
  logic bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [6:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic irq;

  int checks = 0, errors = 0;
  logic [6:0] exp_raw = 7'h08, exp_mask = 7'h00;

  always #10 clk = ~clk;

  ssp_irq_status #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .rx_push(rx_push), .rx_timeout(rx_timeout), .dma_rx_done(dma_rx_done),
    .dma_tx_done(dma_tx_done), .eot_pulse(eot_pulse), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [6:0] model_next(logic [6:0] r);
    logic [6:0] n, clr, set;
    clr = (bus_wr && bus_addr == 2'd3) ? bus_wdata : 7'h0;
    set = '0;
    set[0] = rx_push && rx_level == CNT_W'(DEPTH);
    set[1] = rx_timeout;
    set[4] = dma_rx_done;
    set[5] = dma_tx_done;
    set[6] = eot_pulse && tx_level == 0;
    n = set | (r & ~clr);
    n[2] = rx_level >= CNT_W'(DEPTH / 2);
    n[3] = tx_level <= CNT_W'(DEPTH / 2);
    return n;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic read_all();
    bus_wr = 0;
    bus_addr = 2'd0; #1;
    check("R1 reserved", {25'h0, bus_rdata[31:7]}, 32'h0);
    check("R4 tx threshold", {31'h0, bus_rdata[3]}, {31'h0, exp_raw[3]});
    check("R5 rx threshold", {31'h0, bus_rdata[2]}, {31'h0, exp_raw[2]});
    check("R7 sticky bits", bus_rdata & 32'h73, {25'h0, exp_raw} & 32'h73);
    bus_addr = 2'd1; #1;
    check("R10 mask readback", bus_rdata, {25'h0, exp_mask});
    bus_addr = 2'd2; #1;
    check("R10 masked status", bus_rdata, {25'h0, exp_raw & exp_mask});
    check("R10 irq", {31'h0, irq}, {31'h0, |(exp_raw & exp_mask)});
    bus_addr = 2'd3; #1;
    check("R10 clear reads zero", bus_rdata, 32'h0);
  endtask

  // inputs already driven; apply one edge, update model, then check
  task automatic cyc();
    logic [6:0] nr, nm;
    nr = model_next(exp_raw);
    nm = (bus_wr && bus_addr == 2'd1) ? bus_wdata : exp_mask;
    @(posedge clk);
    @(negedge clk);
    exp_raw = nr;
    exp_mask = nm;
    {rx_push, rx_timeout, dma_rx_done, dma_tx_done, eot_pulse} = '0;
    read_all();
  endtask

  task automatic wr(logic [1:0] a, logic [6:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    cyc();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    bus_addr = 0; #1;
    check("R2 reset raw", bus_rdata, 32'h8);
    bus_addr = 1; #1;
    check("R2 reset mask", bus_rdata, 32'h0);
    check("R2 reset irq", {31'h0, irq}, 32'h0);
    read_all();

    // R3: write all ones to raw address
    wr(2'd0, 7'h7F);
    bus_addr = 0; #1;
    check("R3 raw write ignored", bus_rdata, 32'h8);

    // R4/R5 boundaries
    tx_level = 4; rx_level = 3; cyc();
    check("R4 tx at half", {31'h0, bus_rdata[3]}, 32'h0 | 32'h0 | {31'h0, 1'b0} | 0);
    bus_addr = 0; #1;
    check("R4 tx at half set", {31'h0, bus_rdata[3]}, 32'h1);
    check("R5 rx below half clear", {31'h0, bus_rdata[2]}, 32'h0);
    tx_level = 5; rx_level = 4; cyc();
    bus_addr = 0; #1;
    check("R4 tx above half clear", {31'h0, bus_rdata[3]}, 32'h0);
    check("R5 rx at half set", {31'h0, bus_rdata[2]}, 32'h1);

    // R6: eot with non-empty tx fifo ignored, then with empty sets
    eot_pulse = 1; tx_level = 2; cyc();
    bus_addr = 0; #1;
    check("R6 eot ignored while tx busy", {31'h0, bus_rdata[6]}, 32'h0);
    eot_pulse = 1; tx_level = 0; cyc();
    bus_addr = 0; #1;
    check("R6 eot set when empty", {31'h0, bus_rdata[6]}, 32'h1);

    // R8: push into non-full then full fifo
    rx_push = 1; rx_level = 7; cyc();
    bus_addr = 0; #1;
    check("R8 no overrun below full", {31'h0, bus_rdata[0]}, 32'h0);
    rx_push = 1; rx_level = 8; cyc();
    bus_addr = 0; #1;
    check("R8 overrun when full", {31'h0, bus_rdata[0]}, 32'h1);

    // R7: zero write and bit2/3 ones do nothing; then clear
    rx_level = 8; tx_level = 0;
    wr(2'd3, 7'h0C);
    bus_addr = 0; #1;
    check("R7 clear of 2/3 ignored", bus_rdata, 32'h4D);
    wr(2'd3, 7'h01);
    bus_addr = 0; #1;
    check("R7 overrun cleared", bus_rdata, 32'h4C);

    // R9: set and clear same cycle
    dma_rx_done = 1; bus_wr = 1; bus_addr = 3; bus_wdata = 7'h10; cyc();
    bus_addr = 0; #1;
    check("R9 set wins", {31'h0, bus_rdata[4]}, 32'h1);

    // R10 mask
    wr(2'd1, 7'h10);
    check("R10 irq with mask", {31'h0, irq}, 32'h1);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      tx_level    = CNT_W'($urandom_range(0, DEPTH));
      rx_level    = CNT_W'($urandom_range(0, DEPTH));
      rx_push     = ($urandom_range(0, 3) == 0);
      rx_timeout  = ($urandom_range(0, 15) == 0);
      dma_rx_done = ($urandom_range(0, 15) == 0);
      dma_tx_done = ($urandom_range(0, 15) == 0);
      eot_pulse   = ($urandom_range(0, 7) == 0);
      bus_wr      = ($urandom_range(0, 3) == 0);
      bus_addr    = 2'($urandom_range(0, 3));
      bus_wdata   = 7'($urandom);
      cyc();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule